// File: doc/BRIEF.md
# Address Command Encoder with Serial CRC4

This block turns one access request into a complete command message for a serial link. A request names a 2-bit target id, a 21-bit byte address, an access size of 1, 2 or 4 bytes, a direction, and up to four bytes of write data. The encoder remembers the word address of the last access that completed successfully. It picks the shortest of three address forms. A repeat of the same word uses a 2-bit opcode and only the two low address bits. A nearby word on the same target uses a signed 9-bit offset. Anything else uses the full 21-bit address.

Once the fields are laid out, the encoder shifts the message through a one-bit-per-cycle CRC4 register. That register is seeded with an implicit leading 1. The 4-bit remainder is then appended. The message is offered left-aligned in a 64-bit word together with its total bit count on a valid/ready output. The response side reports back through a small update port. The port either commits the address of the last issued command as the new reference or discards the reference.

Top module: `addrCmdEncoder`

## Requirements
- R1: When there is no valid reference, or the reference has a different id, or the offset is outside -256..+255, the address form is opcode 100 (3 bits) followed by all 21 address bits.
- R2: When the reference is valid and its id and word address (address bits 20:2) equal the request's, the form is opcode 11 (2 bits) followed by address bits 1:0 only.
- R3: Otherwise, when the reference is valid, the id matches, and (address - reference word address) lies in -256..+255, the form is opcode 101 followed by that difference as 9-bit two's complement. Offsets +255 and -256 are inside the range and +256 is outside it.
- R4: reqSize 0 means 1 byte, with the size bit 0 and the address field unchanged. reqSize 1 means 2 bytes, with address field bit 0 forced to 0 and the size bit 1. reqSize 2 or 3 means 4 bytes, with address field bits 1:0 forced to 01 and the size bit 1.
- R5: Field order is id (2 bits), opcode, direction bit (1 = read, 0 = write), address field, size bit. Writes then carry the data bytes, 8 bits each, byte reqData[7:0] first. Reads carry no data.
- R6: The last 4 bits are the CRC of polynomial x^4+x^2+x+1 with initial value 0. The CRC is taken MSB first over a leading 1 followed by every preceding message bit.
- R7: The message's first bit sits at msgData[63]. msgBits gives the total length including the CRC, between 12 and 64. All bits below the message are 0.
- R8: A pulse on lastUpdValid with lastUpdOk=1 makes the id and word address of the most recently accepted request the reference. With lastUpdOk=0 it invalidates the reference.
- R9: reqReady is high only while idle. Once msgValid rises, msgData and msgBits hold steady until msgReady is seen. After that handshake the encoder is idle again.
- R10: After reset the encoder is idle (reqReady=1, msgValid=0) and has no valid reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Encoder idle, request accepted on this edge |
| reqId | input | 2 | Target id |
| reqAddr | input | 21 | Byte address |
| reqSize | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqData | input | 32 | Write data, byte [7:0] sent first |
| msgValid | output | 1 | Encoded message available |
| msgReady | input | 1 | Consumer takes the message |
| msgData | output | 64 | Left-aligned message including CRC |
| msgBits | output | 7 | Message length in bits |
| lastUpdValid | input | 1 | Reference update strobe |
| lastUpdOk | input | 1 | 1: commit last request address, 0: invalidate |

## Verification
The assertions assume that the consumer keeps sampling msgData and msgBits only while msgValid is high. They also assume that request fields are meaningful only in the cycle reqValid meets reqReady. Stability is therefore asserted on the output side alone.

The bench presents each request for exactly one idle cycle. It pulses the update port only between commands, never in the same cycle as an acceptance, so the reference used by each command is unambiguous. Backpressure is produced by holding msgReady low for several cycles before the handshake.

// File: rtl/encPkg.sv
package encPkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic load;    // capture a new request and its laid-out frame
    logic shift;   // advance the CRC register by one message bit
    logic append;  // write the final CRC remainder into the frame
  } encStrobe_t;

  localparam logic [1:0] OP_SAME = 2'b11;
  localparam logic [2:0] OP_REL  = 3'b101;
  localparam logic [2:0] OP_ABS  = 3'b100;
endpackage

// File: rtl/encCtrl.sv
module encCtrl
  import encPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       msgReady,
  input  logic       lastBit,
  output logic       reqReady,
  output logic       msgValid,
  output encStrobe_t strobe
);
  typedef enum logic [1:0] {IDLE, SHIFT, DONE} state_t;
  state_t state;

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else begin
      case (state)
        IDLE:    if (reqValid) state <= SHIFT;
        SHIFT:   if (lastBit)  state <= DONE;
        DONE:    if (msgReady) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady      = (state == IDLE);
    msgValid      = (state == DONE);
    strobe.load   = (state == IDLE) && reqValid;
    strobe.shift  = (state == SHIFT);
    strobe.append = (state == SHIFT) && lastBit;
  end
endmodule

// File: rtl/encDatapath.sv
module encDatapath
  import encPkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 21,
  parameter int REL_W  = 9,
  parameter int DATA_W = 32,
  parameter int MSG_W  = 64,
  parameter int CRC_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  encStrobe_t         strobe,
  input  logic [ID_W-1:0]    reqId,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqSize,
  input  logic               reqWrite,
  input  logic [DATA_W-1:0]  reqData,
  input  logic               lastUpdValid,
  input  logic               lastUpdOk,
  output logic               lastBit,
  output logic [MSG_W-1:0]   msgData,
  output logic [$clog2(MSG_W+1)-1:0] msgBits
);
  localparam int CNT_W   = $clog2(MSG_W + 1);
  localparam int WORD_W  = ADDR_W - 2;
  localparam int DIFF_W  = ADDR_W + 2;
  localparam int NBYTES  = DATA_W / 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0111; // x^4+x^2+x+1 without top term
  localparam logic [CRC_W-1:0] CRC_SEED = 4'b0111; // state after the leading 1

  // reference address
  logic              lastValid;
  logic [ID_W-1:0]   lastId;
  logic [WORD_W-1:0] lastWord;
  logic [ID_W-1:0]   pendId;
  logic [WORD_W-1:0] pendWord;

  // working registers
  logic [MSG_W-1:0] shiftReg;
  logic [MSG_W-1:0] frameReg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lenReg;
  logic [CRC_W-1:0] crc;
  logic [CRC_W-1:0] crcNext;

  // frame layout
  logic [DIFF_W-1:0] diff;
  logic              idMatch, isSame, relOk;
  logic [MSG_W-1:0]  acc, frameAl;
  logic [CNT_W-1:0]  len;
  logic [ADDR_W-1:0] fieldV;
  logic [CNT_W-1:0]  fieldW;
  logic              sizeBit;

  always_comb begin
    diff    = {2'b00, reqAddr} - {2'b00, lastWord, 2'b00};
    idMatch = lastValid && (lastId == reqId);
    isSame  = idMatch && (lastWord == reqAddr[ADDR_W-1:2]);
    relOk   = idMatch && ((&diff[DIFF_W-1:REL_W-1]) || !(|diff[DIFF_W-1:REL_W-1]));

    acc = MSG_W'(reqId);
    len = CNT_W'(ID_W);
    if (isSame) begin
      acc    = (acc << 2) | MSG_W'(OP_SAME);
      len    = len + 2;
      fieldW = 2;
      fieldV = ADDR_W'(reqAddr[1:0]);
    end else if (relOk) begin
      acc    = (acc << 3) | MSG_W'(OP_REL);
      len    = len + 3;
      fieldW = CNT_W'(REL_W);
      fieldV = ADDR_W'(diff[REL_W-1:0]);
    end else begin
      acc    = (acc << 3) | MSG_W'(OP_ABS);
      len    = len + 3;
      fieldW = CNT_W'(ADDR_W);
      fieldV = reqAddr;
    end

    sizeBit = (reqSize != 2'd0);
    if (reqSize == 2'd1) fieldV[0] = 1'b0;
    else if (reqSize[1]) fieldV[1:0] = 2'b01;

    acc = (acc << 1) | MSG_W'(!reqWrite);
    len = len + 1;
    acc = (acc << fieldW) | MSG_W'(fieldV);
    len = len + fieldW;
    acc = (acc << 1) | MSG_W'(sizeBit);
    len = len + 1;

    for (int i = 0; i < NBYTES; i++) begin
      if (reqWrite && ((i == 0) || (i == 1 && sizeBit) || reqSize[1])) begin
        acc = (acc << 8) | MSG_W'(reqData[8*i +: 8]);
        len = len + 8;
      end
    end

    frameAl = acc << (CNT_W'(MSG_W) - len);
  end

  always_comb begin
    crcNext = {crc[CRC_W-2:0], 1'b0} ^ ({CRC_W{crc[CRC_W-1] ^ shiftReg[MSG_W-1]}} & CRC_POLY);
    lastBit = (cnt == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      frameReg <= '0;
      cnt      <= '0;
      lenReg   <= '0;
      crc      <= '0;
      pendId   <= '0;
      pendWord <= '0;
    end else begin
      if (strobe.load) begin
        shiftReg <= frameAl;
        frameReg <= frameAl;
        cnt      <= len;
        lenReg   <= len;
        crc      <= CRC_SEED;
        pendId   <= reqId;
        pendWord <= reqAddr[ADDR_W-1:2];
      end
      if (strobe.shift) begin
        crc      <= crcNext;
        shiftReg <= shiftReg << 1;
        cnt      <= cnt - 1'b1;
      end
      if (strobe.append) begin
        frameReg <= frameReg | ({crcNext, {(MSG_W-CRC_W){1'b0}}} >> lenReg);
        lenReg   <= lenReg + CNT_W'(CRC_W);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastValid <= 1'b0;
      lastId    <= '0;
      lastWord  <= '0;
    end else if (lastUpdValid) begin
      lastValid <= lastUpdOk;
      if (lastUpdOk) begin
        lastId   <= pendId;
        lastWord <= pendWord;
      end
    end
  end

  assign msgData = frameReg;
  assign msgBits = lenReg;
endmodule

// File: rtl/addrCmdEncoder.sv
module addrCmdEncoder
  import encPkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 21,
  parameter int REL_W  = 9,
  parameter int DATA_W = 32,
  parameter int MSG_W  = 64,
  parameter int CNT_W  = $clog2(MSG_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqData,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [MSG_W-1:0]  msgData,
  output logic [CNT_W-1:0]  msgBits,
  input  logic              lastUpdValid,
  input  logic              lastUpdOk
);
  encStrobe_t strobe;
  logic       lastBit;

  encCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .msgReady(msgReady),
    .lastBit(lastBit), .reqReady(reqReady), .msgValid(msgValid), .strobe(strobe)
  );

  encDatapath #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .REL_W(REL_W), .DATA_W(DATA_W), .MSG_W(MSG_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqId(reqId), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqData(reqData),
    .lastUpdValid(lastUpdValid), .lastUpdOk(lastUpdOk), .lastBit(lastBit),
    .msgData(msgData), .msgBits(msgBits)
  );
endmodule

// File: rtl/encChecker.sv
module encChecker #(
  parameter int MSG_W = 64,
  parameter int CNT_W = $clog2(MSG_W + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             msgValid,
  input logic             msgReady,
  input logic [MSG_W-1:0] msgData,
  input logic [CNT_W-1:0] msgBits
);
  // R9
  hold_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgData) && $stable(msgBits));

  // R9
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && msgValid));

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R7
  len_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgBits >= CNT_W'(12)) && (msgBits <= CNT_W'(MSG_W)));

  // R7
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> ((msgData << msgBits) == '0));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgReady |=> reqReady);
endmodule

bind addrCmdEncoder encChecker #(.MSG_W(MSG_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .msgValid(msgValid), .msgReady(msgReady), .msgData(msgData), .msgBits(msgBits)
);

// File: tb/tb_addrCmdEncoder.sv
module tb_addrCmdEncoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqId = '0;
  logic [20:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqData = '0;
  logic        msgValid;
  logic        msgReady = 1'b0;
  logic [63:0] msgData;
  logic [6:0]  msgBits;
  logic        lastUpdValid = 1'b0;
  logic        lastUpdOk = 1'b0;

  int checks = 0;
  int errors = 0;

  // bench reference model
  bit          mValid = 0;
  logic [1:0]  mId = '0;
  logic [18:0] mWord = '0;
  logic [1:0]  pId = '0;
  logic [18:0] pWord = '0;

  always #4 clk = ~clk;

  addrCmdEncoder dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqId(reqId), .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite),
    .reqData(reqData), .msgValid(msgValid), .msgReady(msgReady),
    .msgData(msgData), .msgBits(msgBits), .lastUpdValid(lastUpdValid),
    .lastUpdOk(lastUpdOk)
  );

  function automatic logic [3:0] crcTab(input logic [3:0] n);
    case (n)
      4'h0: return 4'h0; 4'h1: return 4'h7; 4'h2: return 4'hE; 4'h3: return 4'h9;
      4'h4: return 4'hB; 4'h5: return 4'hC; 4'h6: return 4'h5; 4'h7: return 4'h2;
      4'h8: return 4'h1; 4'h9: return 4'h6; 4'hA: return 4'hF; 4'hB: return 4'h8;
      4'hC: return 4'hA; 4'hD: return 4'hD; 4'hE: return 4'h4; default: return 4'h3;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R7: independent message construction
  task automatic expMsg(input logic [1:0] id, input logic [20:0] a, input int sz,
                        input bit wr, input logic [31:0] d,
                        output logic [63:0] m, output int nb);
    logic [63:0] acc;
    logic [63:0] v;
    logic [20:0] af;
    logic [3:0]  c;
    int n, op, opb, ab, rel, t, nbytes;
    bit ds;
    rel = int'(a) - int'({mWord, 2'b00});
    if (mValid && mId == id && mWord == a[20:2]) begin
      op = 3; opb = 2; ab = 2; af = {19'd0, a[1:0]};
    end else if (mValid && mId == id && rel >= -256 && rel <= 255) begin
      op = 5; opb = 3; ab = 9; af = 21'(rel & 511);
    end else begin
      op = 4; opb = 3; ab = 21; af = a;
    end
    ds = (sz != 0);
    if (sz == 1) af[0] = 1'b0;
    if (sz >= 2) af[1:0] = 2'b01;
    nbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    acc = 64'(id); n = 2;
    acc = (acc << opb) | 64'(op); n += opb;
    acc = (acc << 1) | 64'(!wr); n += 1;
    acc = (acc << ab) | 64'(af); n += ab;
    acc = (acc << 1) | 64'(ds); n += 1;
    if (wr) for (int i = 0; i < nbytes; i++) begin
      acc = (acc << 8) | 64'(d[8*i +: 8]); n += 8;
    end
    v = acc | (64'd1 << n);
    t = ((n + 1 + 3) / 4) * 4;
    c = 4'h0;
    for (int i = t - 4; i >= 0; i -= 4) c = crcTab(c ^ 4'((v >> i) & 64'hF));
    acc = (acc << 4) | 64'(c); n += 4;
    m = acc << (64 - n);
    nb = n;
  endtask

  task automatic sendCmd(input string tag, input logic [1:0] id, input logic [20:0] a,
                         input int sz, input bit wr, input logic [31:0] d, input int hold);
    logic [63:0] em;
    int en, w;
    logic [63:0] snap;
    expMsg(id, a, sz, wr, d, em, en);
    reqId = id; reqAddr = a; reqSize = 2'(sz); reqWrite = wr; reqData = d;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    pId = id; pWord = a[20:2];
    check({tag, " R9 busy after accept"}, 64'(reqReady), 64'd0);
    w = 0;
    while (!msgValid && w < 200) begin @(negedge clk); w++; end
    check({tag, " R6 R7 message"}, msgData, em);
    check({tag, " R7 length"}, 64'(msgBits), 64'(en));
    snap = msgData;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check({tag, " R9 held while stalled"}, {63'd0, msgValid}, 64'd1);
      check({tag, " R9 data stable"}, msgData, snap);
    end
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
    check({tag, " R9 idle after handshake"}, 64'(reqReady), 64'd1);
  endtask

  task automatic upd(input bit ok);
    lastUpdValid = 1'b1; lastUpdOk = ok;
    @(negedge clk);
    lastUpdValid = 1'b0;
    if (ok) begin mValid = 1; mId = pId; mWord = pWord; end
    else mValid = 0;
  endtask

  task automatic testReset;
    check("R10 reqReady after reset", 64'(reqReady), 64'd1);
    check("R10 msgValid after reset", 64'(msgValid), 64'd0);
  endtask

  task automatic testForms;
    sendCmd("R1 absolute R4 4B", 2'd0, 21'h000100, 2, 0, 32'h0, 0);
    upd(1);
    sendCmd("R2 same R8 commit", 2'd0, 21'h000102, 2, 0, 32'h0, 0);
    upd(1);
    sendCmd("R3 rel +255 R4 2B", 2'd0, 21'h0001FF, 1, 0, 32'h0, 0);
    upd(1);
    sendCmd("R3 rel -256 R4 1B", 2'd0, 21'h0000FC, 0, 0, 32'h0, 0);
    upd(1);
    sendCmd("R3 +256 goes R1", 2'd0, 21'h0001FC, 2, 0, 32'h0, 0);
    upd(1);
    sendCmd("R1 other id R5 4B write", 2'd1, 21'h0001FC, 2, 1, 32'hA5C3_1E77, 0);
    upd(0);
    sendCmd("R8 invalidated R1", 2'd1, 21'h0001FC, 2, 0, 32'h0, 0);
  endtask

  task automatic testWrites;
    upd(1);
    sendCmd("R5 1B write R2", 2'd1, 21'h0001FD, 0, 1, 32'h0000_00B6, 0);
    upd(1);
    sendCmd("R5 2B write R3", 2'd1, 21'h000183, 1, 1, 32'h0000_9C41, 0);
    sendCmd("R1 max address R4 size3", 2'd3, 21'h1FFFFF, 3, 0, 32'h0, 0);
  endtask

  task automatic testBackpressure;
    sendCmd("R9 stall", 2'd2, 21'h0ABCDE, 2, 1, 32'h1234_5678, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testForms();
    testWrites();
    testBackpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule